// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block is a 32-pin general-purpose I/O port controlled through a small memory-mapped register window. A host presents a byte offset, a write strobe and a 32-bit write word; read data comes back combinationally for whatever offset is on the address bus. The port drives a pad output-enable vector and a pad output-data vector, and it samples a pad input vector through a two-flop synchronizer.

Direction is never written as a whole word. One strobe register turns selected pins into outputs and another turns selected pins into inputs, so independent software agents can reconfigure their own pins without a read-modify-write. Output levels are split across two half-port registers. Every write to one of them carries a 16-bit mask in its upper half and 16 new levels in its lower half, and only the masked pins change. The output latch keeps its value while a pin is an input, so software can preload a level and then enable the driver without a glitch.

The register interface is a plain address/strobe/data port with no back-pressure: every write is accepted in the cycle its strobe is high, and a read needs no request. No stream data passes through the block, so it has no valid/ready pair.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset every pin is an input (pad_oe all 0), every output latch is 0 (pad_out all 0), and reads of offsets 0x00, 0x04, 0x08 and 0x0C return 0.
- R2: A write to offset 0x00 makes a pin an output wherever the write word has a 1. Pins whose bit is 0 keep their direction. The new value appears on pad_oe after the clock edge that takes the write.
- R3: A write to offset 0x04 makes a pin an input wherever the write word has a 1. Pins whose bit is 0 keep their direction.
- R4: A write to offset 0x08 sets the output latch of pin i (0 to 15) to write bit i wherever write bit 16+i is 1. Latches whose mask bit is 0 keep their value.
- R5: A write to offset 0x0C sets the output latch of pin 16+i to write bit i wherever write bit 16+i is 1. Latches whose mask bit is 0 keep their value.
- R6: pad_out always shows the output latches, whatever the direction. A change of direction never changes a latch.
- R7: Reading offset 0x10 returns pad_in as it was sampled two rising clock edges earlier, bit i for pin i.
- R8: Reads of 0x00 and 0x04 both return the direction vector (1 = output). Reads of 0x08 and 0x0C return the latches of pins 0..15 and 16..31 in bits 15:0, with bits 31:16 zero.
- R9: Reads of any other offset, including offsets that are not multiples of 4, return 0. Writes to such offsets and writes to 0x10 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_wdata | input | 32 | Write word |
| reg_rdata | output | 32 | Read word for reg_addr (combinational) |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_oe | output | 32 | Pad output enables, 1 = pin drives |
| pad_out | output | 32 | Pad output levels |

## Verification
The masked half-port writes use masks that are all ones, a partial nibble, and two isolated bits at the ends of the upper half. These show whether the mask gates each bit on its own and whether the two halves are routed to the correct pins. The direction strobes use words with zero bits, with an all-zero word and with an all-ones word, which shows whether set and clear touch only the named pins. Toggling direction while the latched level is read back shows whether the latch is independent of direction. The input path is stepped one edge at a time with distinct patterns to confirm the two-edge delay exactly. Writes to unmapped, unaligned and read-only offsets confirm that state does not move.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned BANK_DW = 32;

  localparam logic [7:0] OFS_MAKE_OUT = 8'h00;
  localparam logic [7:0] OFS_MAKE_IN  = 8'h04;
  localparam logic [7:0] OFS_LVL_LO   = 8'h08;
  localparam logic [7:0] OFS_LVL_HI   = 8'h0C;
  localparam logic [7:0] OFS_PIN_IN   = 8'h10;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MAKE_OUT,
    SEL_MAKE_IN,
    SEL_LVL_LO,
    SEL_LVL_HI,
    SEL_PIN_IN
  } bank_sel_e;

endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic            clr_en,
  input  logic [PINS-1:0] bits,
  output logic [PINS-1:0] dir_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (set_en) dir_q <= dir_q | bits;
    else if (clr_en) dir_q <= dir_q & ~bits;
  end

  assert_make_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((dir_q & $past(bits)) == $past(bits)));

  assert_make_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((dir_q & $past(bits)) == '0));

  assert_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en || clr_en) |=> ((dir_q & ~$past(bits)) == ($past(dir_q) & ~$past(bits))));

  assert_dir_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(dir_q));

endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half #(
  parameter int unsigned HALF = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [HALF-1:0] mask,
  input  logic [HALF-1:0] level,
  output logic [HALF-1:0] lat_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= '0;
    else if (wr_en) lat_q <= (lat_q & ~mask) | (level & mask);
  end

  // Holds for both halves (R4 low, R5 high).
  assert_masked_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((lat_q ^ $past(level)) & $past(mask)) == '0) &&
              (((lat_q ^ $past(lat_q)) & ~$past(mask)) == '0));

  assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(lat_q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned PINS   = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] pad_in,
  output logic [PINS-1:0] sync_q
);

  logic [PINS-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= pad_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_q = stage_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            warm_q <= '0;
      else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assert_two_edge_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q == 2'd2) |-> (sync_q == $past(pad_in, 2)));
  end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PINS        = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_oe,
  output logic [PINS-1:0]   pad_out
);

  localparam int unsigned HALF  = PINS / 2;
  localparam int unsigned NHALF = 2;

  bank_sel_e       sel;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] pin_sync;
  logic [HALF-1:0] lat_q [NHALF];

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(OFS_MAKE_OUT): sel = SEL_MAKE_OUT;
      ADDR_W'(OFS_MAKE_IN):  sel = SEL_MAKE_IN;
      ADDR_W'(OFS_LVL_LO):   sel = SEL_LVL_LO;
      ADDR_W'(OFS_LVL_HI):   sel = SEL_LVL_HI;
      ADDR_W'(OFS_PIN_IN):   sel = SEL_PIN_IN;
      default:               sel = SEL_NONE;
    endcase
  end

  gpio_dir_reg #(.PINS(PINS)) u_dir (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_en (reg_wr && sel == SEL_MAKE_OUT),
    .clr_en (reg_wr && sel == SEL_MAKE_IN),
    .bits   (reg_wdata[PINS-1:0]),
    .dir_q  (dir_q)
  );

  for (genvar h = 0; h < NHALF; h++) begin : g_half
    localparam bank_sel_e MY_SEL = (h == 0) ? SEL_LVL_LO : SEL_LVL_HI;
    gpio_out_half #(.HALF(HALF)) u_half (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_wr && sel == MY_SEL),
      .mask  (reg_wdata[HALF +: HALF]),
      .level (reg_wdata[0 +: HALF]),
      .lat_q (lat_q[h])
    );
    assign pad_out[h*HALF +: HALF] = lat_q[h];
  end

  gpio_in_sync #(.PINS(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (pad_in),
    .sync_q (pin_sync)
  );

  assign pad_oe = dir_q;

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_MAKE_OUT, SEL_MAKE_IN: reg_rdata[PINS-1:0] = dir_q;
      SEL_LVL_LO:                reg_rdata[HALF-1:0] = lat_q[0];
      SEL_LVL_HI:                reg_rdata[HALF-1:0] = lat_q[1];
      SEL_PIN_IN:                reg_rdata[PINS-1:0] = pin_sync;
      default:                   reg_rdata = '0;
    endcase
  end

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && sel == SEL_NONE) |=> ($stable(pad_oe) && $stable(pad_out)));

  assert_level_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_LVL_LO || sel == SEL_LVL_HI) |-> (reg_rdata[31:HALF] == '0));

  assert_dir_no_glitch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (sel == SEL_MAKE_OUT || sel == SEL_MAKE_IN)) |=> $stable(pad_out));

endmodule

// File: tb/gpio_port_bank_test.sv
module gpio_port_bank_test;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [7:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h08, 32'hFFFF_A5A5, 8'h08, 32'h0000_A5A5, 4'd4}, // R4 full mask
    '{1'b1, 8'h08, 32'h000F_0000, 8'h08, 32'h0000_A5A0, 4'd4}, // R4 partial mask
    '{1'b1, 8'h0C, 32'h8001_FFFF, 8'h0C, 32'h0000_8001, 4'd5}, // R5 end bits
    '{1'b1, 8'h00, 32'h0000_00FF, 8'h00, 32'h0000_00FF, 4'd2}, // R2
    '{1'b1, 8'h00, 32'h8000_0000, 8'h04, 32'h8000_00FF, 4'd8}, // R2 keep, R8 alias
    '{1'b1, 8'h04, 32'h0000_000F, 8'h00, 32'h8000_00F0, 4'd3}, // R3
    '{1'b1, 8'h04, 32'h0000_0000, 8'h00, 32'h8000_00F0, 4'd3}, // R3 zero word
    '{1'b1, 8'h14, 32'hFFFF_FFFF, 8'h00, 32'h8000_00F0, 4'd9}, // R9 unmapped write
    '{1'b0, 8'h00, 32'h0000_0000, 8'h14, 32'h0000_0000, 4'd9}, // R9 unmapped read
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 8'h08, 32'h0000_A5A0, 4'd9}, // R9 read-only write
    '{1'b1, 8'h04, 32'hFFFF_FFFF, 8'h08, 32'h0000_A5A0, 4'd6}, // R6 latch kept
    '{1'b0, 8'h00, 32'h0000_0000, 8'h0C, 32'h0000_8001, 4'd6}, // R6
    '{1'b1, 8'h02, 32'hFFFF_FFFF, 8'h00, 32'h0000_0000, 4'd9}  // R9 unaligned
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_oe;
  logic [31:0] pad_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port_bank uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, v); check("R1", v, 32'h0);
    rd(8'h04, v); check("R1", v, 32'h0);
    rd(8'h08, v); check("R1", v, 32'h0);
    rd(8'h0C, v); check("R1", v, 32'h0);
    check("R1", pad_oe, 32'h0);
    check("R1", pad_out, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) wr(TBL[i].addr, TBL[i].data);
      rd(TBL[i].raddr, v);
      check($sformatf("R%0d vec%0d", TBL[i].req, i), v, TBL[i].exp);
    end

    // R6 pad_out follows latches while all pins are inputs
    check("R3", pad_oe, 32'h0);
    check("R6", pad_out, 32'h8001_A5A0);
    wr(8'h00, 32'h0000_FFFF);
    #1;
    check("R2", pad_oe, 32'h0000_FFFF);
    check("R6", pad_out, 32'h8001_A5A0);

    // R7 two-edge input delay
    @(negedge clk);
    pad_in = 32'h1234_5678; reg_addr = 8'h10;
    #1 check("R7 edge0", reg_rdata, 32'h0);
    @(negedge clk); #1 check("R7 edge1", reg_rdata, 32'h0);
    @(negedge clk); #1 check("R7 edge2", reg_rdata, 32'h1234_5678);
    pad_in = 32'hFFFF_FFFF;
    @(negedge clk); #1 check("R7 edge1", reg_rdata, 32'h1234_5678);
    @(negedge clk); #1 check("R7 edge2", reg_rdata, 32'hFFFF_FFFF);
    pad_in = 32'h0;
    repeat (2) @(negedge clk);
    #1 check("R7 zero", reg_rdata, 32'h0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule